// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading translation descriptors from memory. A requester presents one address at a time. When translation is on, the walker fetches a first-level descriptor and, if that descriptor points to a coarse table, a second-level descriptor. It then forms the physical address from the mapping the descriptors describe. Four mapping sizes are decoded: 16 MB, 1 MB, 64 KB and 4 KB. In every case the page-offset bits of the virtual address pass through to the physical address unchanged.

Descriptor reads go out over a plain read port. The port carries one outstanding read at a time and uses a request/acknowledge handshake. Any invalid descriptor ends the walk with a fault. A fault also sets an interrupt line, which stays high until the host clears it with a one-cycle clear input. When translation is off, which is the state after reset, addresses pass straight through and no memory is read.

Top module: `ptw_walker`

## Requirements
- R1: During and right after reset, `req_ready` is 1 and `rsp_done`, `mem_rd` and `fault_irq` are 0.
- R2: With `xlat_en` low at acceptance, `rsp_done` rises the cycle after acceptance with `rsp_paddr` equal to the virtual address and `rsp_fault` 0, and no memory read is issued.
- R3: The first-level read address is `(tbl_base with bits [6:0] cleared) + {vaddr[31:20], 2'b00}`. `mem_rd` stays high with a stable, word-aligned `mem_addr` until a cycle with `mem_ack` high.
- R4: A first-level descriptor whose bits [1:0] are 00 or 11 ends the walk with `rsp_fault` 1 and `rsp_paddr` 0.
- R5: A first-level descriptor with bits [1:0] = 10 and bit 18 = 0 gives `rsp_paddr = {desc[31:20], vaddr[19:0]}`.
- R6: A first-level descriptor with bits [1:0] = 10 and bit 18 = 1 gives `rsp_paddr = {desc[31:24], vaddr[23:0]}`.
- R7: A first-level descriptor with bits [1:0] = 01 starts a second read at `{desc[31:10], vaddr[19:12], 2'b00}`.
- R8: A second-level descriptor with bits [1:0] = 00 ends the walk with `rsp_fault` 1 and `rsp_paddr` 0.
- R9: A second-level descriptor with bits [1:0] = 01 gives `rsp_paddr = {desc[31:16], vaddr[15:0]}`.
- R10: A second-level descriptor with bits [1:0] = 10 or 11 gives `rsp_paddr = {desc[31:12], vaddr[11:0]}`.
- R11: `req_ready` is low from the cycle after acceptance through the `rsp_done` cycle. `rsp_done` is a one-cycle pulse in the cycle after the last read acknowledge, or in the cycle after acceptance for a bypass.
- R12: `fault_irq` rises together with a faulting `rsp_done`. It stays high until a cycle with `irq_clear` high. A new fault in the same cycle as a clear leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xlat_en | input | 1 | Translation enable, sampled at acceptance |
| tbl_base | input | 32 | First-level table base; bits [6:0] are ignored |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address of the request |
| req_ready | output | 1 | Walker idle and able to accept |
| rsp_done | output | 1 | One-cycle result strobe |
| rsp_paddr | output | 32 | Physical address, valid with `rsp_done` |
| rsp_fault | output | 1 | Walk ended on an invalid descriptor |
| mem_rd | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor read address |
| mem_rdata | input | 32 | Descriptor read data, valid with `mem_ack` |
| mem_ack | input | 1 | Read completes this cycle |
| fault_irq | output | 1 | Sticky fault interrupt |
| irq_clear | input | 1 | Write-one-to-clear for `fault_irq` |

## Verification
Every cycle, the assertions check the read-port handshake (a stalled read keeps its address, and addresses stay word-aligned) and the busy window around each request. They also check that `rsp_done` is a single pulse, that a bypass finishes one cycle after acceptance with the address unchanged, and that the interrupt is set on a faulting result and held until it is cleared. Only the bench scenarios can show that each descriptor type selects the right mapping size and address split, that both fetch addresses are composed correctly from the base, the descriptor and the index bits, and that the interrupt survives a set and a clear in the same cycle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   // Outcome of decoding one translation descriptor
   typedef enum logic [1:0] {
      DK_FAULT = 2'd0,
      DK_TABLE = 2'd1,
      DK_MAP   = 2'd2
   } desc_kind_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_L1   = 2'd1,
      ST_L2   = 2'd2,
      ST_RESP = 2'd3
   } walk_state_t;

endpackage

// File: rtl/ptw_desc_decode.sv
// Decodes one descriptor word. LEVEL picks the first- or second-level variant.
// HI_OFF_W / LO_OFF_W are the offset widths of the larger / smaller mapping.
module ptw_desc_decode
   import ptw_pkg::*;
#(
   parameter int LEVEL     = 1,
   parameter int VA_W      = 32,
   parameter int SUPER_BIT = 18,
   parameter int HI_OFF_W  = 24,
   parameter int LO_OFF_W  = 20
) (
   input  logic [VA_W-1:0] desc,
   input  logic [VA_W-1:0] vaddr,
   output desc_kind_t      kind,
   output logic [VA_W-1:0] paddr
);

   localparam logic [VA_W-1:0] HI_MASK = VA_W'((64'd1 << HI_OFF_W) - 64'd1);
   localparam logic [VA_W-1:0] LO_MASK = VA_W'((64'd1 << LO_OFF_W) - 64'd1);

   logic [VA_W-1:0] pa_hi;
   logic [VA_W-1:0] pa_lo;

   assign pa_hi = (desc & ~HI_MASK) | (vaddr & HI_MASK);
   assign pa_lo = (desc & ~LO_MASK) | (vaddr & LO_MASK);

   if (HI_OFF_W <= LO_OFF_W || HI_OFF_W >= VA_W) begin : g_bad_widths
      $error("ptw_desc_decode: HI_OFF_W must lie between LO_OFF_W and VA_W");
   end

   if (LEVEL == 1) begin : g_first
      // 01 -> coarse table, 10 -> section/supersection, 00/11 -> invalid
      always_comb begin
         paddr = '0;
         unique case (desc[1:0])
            2'b01: kind = DK_TABLE;
            2'b10: begin
               kind  = DK_MAP;
               paddr = desc[SUPER_BIT] ? pa_hi : pa_lo;
            end
            default: kind = DK_FAULT;
         endcase
      end
   end else if (LEVEL == 2) begin : g_second
      // 01 -> large page, 1x -> small page, 00 -> invalid
      always_comb begin
         paddr = '0;
         kind  = DK_FAULT;
         if (desc[1]) begin
            kind  = DK_MAP;
            paddr = pa_lo;
         end else if (desc[0]) begin
            kind  = DK_MAP;
            paddr = pa_hi;
         end
      end
   end else begin : g_bad_level
      $error("ptw_desc_decode: LEVEL must be 1 or 2");
      assign kind  = DK_FAULT;
      assign paddr = '0;
   end

endmodule

// File: rtl/ptw_irq_latch.sv
// Sticky interrupt: a set wins over a simultaneous clear.
module ptw_irq_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq <= 1'b0;
      end else if (set) begin
         irq <= 1'b1;
      end else if (clr) begin
         irq <= 1'b0;
      end
   end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int VA_W        = 32,
   parameter int L1_IDX_W    = 12,
   parameter int L2_IDX_W    = 8,
   parameter int SUPER_OFF_W = 24,
   parameter int LARGE_OFF_W = 16,
   parameter int SUPER_BIT   = 18,
   parameter int BASE_LSB    = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            xlat_en,
   input  logic [VA_W-1:0] tbl_base,
   input  logic            req_valid,
   input  logic [VA_W-1:0] req_vaddr,
   output logic            req_ready,
   output logic            rsp_done,
   output logic [VA_W-1:0] rsp_paddr,
   output logic            rsp_fault,
   output logic            mem_rd,
   output logic [VA_W-1:0] mem_addr,
   input  logic [VA_W-1:0] mem_rdata,
   input  logic            mem_ack,
   output logic            fault_irq,
   input  logic            irq_clear
);

   localparam int SECT_OFF_W  = VA_W - L1_IDX_W;
   localparam int SMALL_OFF_W = SECT_OFF_W - L2_IDX_W;
   localparam int L2_BASE_LSB = L2_IDX_W + 2;
   localparam logic [VA_W-1:0] BASE_MASK = ~VA_W'((64'd1 << BASE_LSB) - 64'd1);

   if (SMALL_OFF_W < 2) begin : g_chk_idx
      $error("ptw_walker: index widths leave no room for the page offset");
   end
   if (SUPER_BIT < 2 || SUPER_BIT >= SECT_OFF_W) begin : g_chk_sbit
      $error("ptw_walker: SUPER_BIT must lie inside the section offset field");
   end
   if (BASE_LSB < 2 || BASE_LSB >= VA_W) begin : g_chk_base
      $error("ptw_walker: BASE_LSB out of range");
   end

   walk_state_t     state_q;
   logic [VA_W-1:0] va_q;
   logic [VA_W-1:0] l2_addr_q;
   logic [VA_W-1:0] paddr_q;
   logic            fault_q;

   desc_kind_t      l1_kind;
   desc_kind_t      l2_kind;
   logic [VA_W-1:0] l1_pa;
   logic [VA_W-1:0] l2_pa;
   logic [VA_W-1:0] l1_fetch;
   logic [VA_W-1:0] l2_fetch;
   logic            walk_fault;

   // descriptor fetch addresses
   assign l1_fetch = (tbl_base & BASE_MASK) + VA_W'({va_q[VA_W-1 -: L1_IDX_W], 2'b00});
   assign l2_fetch = {mem_rdata[VA_W-1:L2_BASE_LSB], va_q[SECT_OFF_W-1 -: L2_IDX_W], 2'b00};

   ptw_desc_decode #(
      .LEVEL     (1),
      .VA_W      (VA_W),
      .SUPER_BIT (SUPER_BIT),
      .HI_OFF_W  (SUPER_OFF_W),
      .LO_OFF_W  (SECT_OFF_W)
   ) u_l1dec (
      .desc  (mem_rdata),
      .vaddr (va_q),
      .kind  (l1_kind),
      .paddr (l1_pa)
   );

   ptw_desc_decode #(
      .LEVEL     (2),
      .VA_W      (VA_W),
      .SUPER_BIT (SUPER_BIT),
      .HI_OFF_W  (LARGE_OFF_W),
      .LO_OFF_W  (SMALL_OFF_W)
   ) u_l2dec (
      .desc  (mem_rdata),
      .vaddr (va_q),
      .kind  (l2_kind),
      .paddr (l2_pa)
   );

   assign walk_fault = mem_ack &&
                       (((state_q == ST_L1) && (l1_kind == DK_FAULT)) ||
                        ((state_q == ST_L2) && (l2_kind != DK_MAP)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         va_q      <= '0;
         l2_addr_q <= '0;
         paddr_q   <= '0;
         fault_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q <= req_vaddr;
                  if (xlat_en) begin
                     state_q <= ST_L1;
                  end else begin
                     paddr_q <= req_vaddr;
                     fault_q <= 1'b0;
                     state_q <= ST_RESP;
                  end
               end
            end
            ST_L1: begin
               if (mem_ack) begin
                  unique case (l1_kind)
                     DK_TABLE: begin
                        l2_addr_q <= l2_fetch;
                        state_q   <= ST_L2;
                     end
                     DK_MAP: begin
                        paddr_q <= l1_pa;
                        fault_q <= 1'b0;
                        state_q <= ST_RESP;
                     end
                     default: begin
                        paddr_q <= '0;
                        fault_q <= 1'b1;
                        state_q <= ST_RESP;
                     end
                  endcase
               end
            end
            ST_L2: begin
               if (mem_ack) begin
                  if (l2_kind == DK_MAP) begin
                     paddr_q <= l2_pa;
                     fault_q <= 1'b0;
                  end else begin
                     paddr_q <= '0;
                     fault_q <= 1'b1;
                  end
                  state_q <= ST_RESP;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign rsp_done  = (state_q == ST_RESP);
   assign rsp_paddr = paddr_q;
   assign rsp_fault = fault_q;
   assign mem_rd    = (state_q == ST_L1) || (state_q == ST_L2);
   assign mem_addr  = (state_q == ST_L2) ? l2_addr_q : l1_fetch;

   ptw_irq_latch u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (walk_fault),
      .clr   (irq_clear),
      .irq   (fault_irq)
   );

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
   parameter int VA_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            xlat_en,
   input logic [VA_W-1:0] tbl_base,
   input logic            req_valid,
   input logic [VA_W-1:0] req_vaddr,
   input logic            req_ready,
   input logic            rsp_done,
   input logic [VA_W-1:0] rsp_paddr,
   input logic            rsp_fault,
   input logic            mem_rd,
   input logic [VA_W-1:0] mem_addr,
   input logic [VA_W-1:0] mem_rdata,
   input logic            mem_ack,
   input logic            fault_irq,
   input logic            irq_clear
);

   // R3
   read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd && !mem_ack |=> mem_rd && $stable(mem_addr));

   // R3
   read_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> mem_addr[1:0] == 2'b00);

   // R2
   bypass_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && !xlat_en |=>
         rsp_done && !rsp_fault && !mem_rd && rsp_paddr == $past(req_vaddr));

   // R11
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);

   // R11
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done && req_ready);

   // R11
   done_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> !req_ready && !mem_rd);

   // R12
   irq_with_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done && rsp_fault |-> fault_irq);

   // R12
   irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_irq && !irq_clear |=> fault_irq);

endmodule

bind ptw_walker ptw_walker_chk u_chk (.*);

// File: tb/ptw_walker_test.sv
module ptw_walker_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        xlat_en;
   logic [31:0] tbl_base;
   logic        req_valid;
   logic [31:0] req_vaddr;
   logic        req_ready;
   logic        rsp_done;
   logic [31:0] rsp_paddr;
   logic        rsp_fault;
   logic        mem_rd;
   logic [31:0] mem_addr;
   logic [31:0] mem_rdata;
   logic        mem_ack;
   logic        fault_irq;
   logic        irq_clear;

   always #5 clk = ~clk;

   ptw_walker uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .xlat_en   (xlat_en),
      .tbl_base  (tbl_base),
      .req_valid (req_valid),
      .req_vaddr (req_vaddr),
      .req_ready (req_ready),
      .rsp_done  (rsp_done),
      .rsp_paddr (rsp_paddr),
      .rsp_fault (rsp_fault),
      .mem_rd    (mem_rd),
      .mem_addr  (mem_addr),
      .mem_rdata (mem_rdata),
      .mem_ack   (mem_ack),
      .fault_irq (fault_irq),
      .irq_clear (irq_clear)
   );

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   int lat    = 0;
   int wcnt   = 0;
   int reads  = 0;
   int ack_cyc = 0;
   logic [31:0] mem [logic [31:0]];
   logic [31:0] exp_addr [$];
   string       exp_tag  [$];
   logic [31:0] want_addr;
   string       want_tag;

   localparam logic [31:0] TB = 32'h0001_23C5;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   function automatic logic [31:0] l1a(input logic [31:0] va);
      return (TB & 32'hFFFF_FF80) + {18'd0, va[31:20], 2'b00};
   endfunction

   function automatic logic [31:0] l2a(input logic [31:0] d1, input logic [31:0] va);
      return {d1[31:10], va[19:12], 2'b00};
   endfunction

   function automatic logic [31:0] rd(input logic [31:0] a);
      if (mem.exists(a)) return mem[a];
      return 32'h0;
   endfunction

   // memory responder: behavioural, latency set per transaction
   initial begin
      mem_ack   = 1'b0;
      mem_rdata = 32'h0;
      forever begin
         @(negedge clk);
         if (mem_ack) begin
            mem_ack = 1'b0;
            wcnt    = 0;
         end else if (mem_rd) begin
            if (wcnt >= lat) begin
               mem_ack   = 1'b1;
               mem_rdata = rd(mem_addr);
               reads++;
               ack_cyc   = cyc;
               if (exp_addr.size() == 0) begin
                  chk(1'b0, "R2", "unexpected descriptor read", mem_addr, 32'h0);
               end else begin
                  want_addr = exp_addr.pop_front();
                  want_tag  = exp_tag.pop_front();
                  chk(mem_addr == want_addr, want_tag, "fetch address", mem_addr, want_addr);
               end
            end else begin
               wcnt++;
            end
         end
      end
   end

   task automatic xlat(input bit en, input logic [31:0] va, input logic [31:0] ex_pa,
                       input bit ex_fault, input int nrd, input int l, input string rq);
      int n;
      lat   = l;
      reads = 0;
      @(negedge clk);
      chk(req_ready == 1'b1, "R11", "ready before request", {31'd0, req_ready}, 32'd1);
      xlat_en   = en;
      req_vaddr = va;
      req_valid = 1'b1;
      ack_cyc   = cyc;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R11", "busy after accept", {31'd0, req_ready}, 32'd0);
      n = 0;
      while (!rsp_done && n < 200) begin
         @(negedge clk);
         n++;
      end
      chk(rsp_done == 1'b1, rq, "done seen", {31'd0, rsp_done}, 32'd1);
      chk(cyc == ack_cyc + 1, "R11", "done one cycle after last event", cyc, ack_cyc + 1);
      chk(rsp_paddr == ex_pa, rq, "physical address", rsp_paddr, ex_pa);
      chk(rsp_fault == ex_fault, rq, "fault flag", {31'd0, rsp_fault}, {31'd0, ex_fault});
      chk(reads == nrd, rq, "descriptor read count", reads, nrd);
      if (ex_fault)
         chk(fault_irq == 1'b1, "R12", "irq with fault", {31'd0, fault_irq}, 32'd1);
      @(negedge clk);
      chk(!rsp_done && req_ready, "R11", "done is one pulse then ready",
          {30'd0, rsp_done, req_ready}, 32'd1);
   endtask

   task automatic expect_rd(input logic [31:0] a, input string t);
      exp_addr.push_back(a);
      exp_tag.push_back(t);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n     = 1'b0;
      xlat_en   = 1'b0;
      tbl_base  = TB;
      req_valid = 1'b0;
      req_vaddr = 32'h0;
      irq_clear = 1'b0;

      mem[l1a(32'h1234_5678)] = 32'hABC0_0002;
      mem[l1a(32'h2345_6789)] = 32'h5F04_0002;
      mem[l1a(32'h4000_0000)] = 32'h0000_0003;
      mem[l1a(32'h5670_0000)] = 32'h0008_0401;
      mem[32'h0008_0624]      = 32'h7777_0001;
      mem[32'h0008_0448]      = 32'h1357_9002;
      mem[32'h0008_04D0]      = 32'hCAFE_B003;

      repeat (3) @(negedge clk);
      // R1 reset state
      chk(req_ready == 1'b1, "R1", "ready in reset", {31'd0, req_ready}, 32'd1);
      chk(!rsp_done && !mem_rd && !fault_irq, "R1", "quiet in reset",
          {29'd0, rsp_done, mem_rd, fault_irq}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !rsp_done && !mem_rd && !fault_irq, "R1", "state after reset",
          {28'd0, req_ready, rsp_done, mem_rd, fault_irq}, 32'h8);

      // R2 bypass, including an address that has a mapping
      xlat(1'b0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0, 0, 0, "R2");
      xlat(1'b0, 32'h1234_5678, 32'h1234_5678, 1'b0, 0, 2, "R2");

      // R5 section, R3 first-level address
      expect_rd(l1a(32'h1234_5678), "R3");
      xlat(1'b1, 32'h1234_5678, 32'hABC4_5678, 1'b0, 1, 1, "R5");

      // R6 supersection
      expect_rd(l1a(32'h2345_6789), "R3");
      xlat(1'b1, 32'h2345_6789, 32'h5F45_6789, 1'b0, 1, 0, "R6");

      // R4 invalid type 00 and 11
      expect_rd(l1a(32'h3000_0000), "R3");
      xlat(1'b1, 32'h3000_0000, 32'h0, 1'b1, 1, 2, "R4");
      expect_rd(l1a(32'h4000_0000), "R3");
      xlat(1'b1, 32'h4000_0000, 32'h0, 1'b1, 1, 0, "R4");

      // R9 large page via R7 second-level fetch
      expect_rd(l1a(32'h5678_9ABC), "R3");
      expect_rd(l2a(32'h0008_0401, 32'h5678_9ABC), "R7");
      xlat(1'b1, 32'h5678_9ABC, 32'h7777_9ABC, 1'b0, 2, 3, "R9");
      chk(fault_irq == 1'b1, "R12", "irq held after good walk", {31'd0, fault_irq}, 32'd1);

      // R12 clear
      @(negedge clk);
      irq_clear = 1'b1;
      @(negedge clk);
      irq_clear = 1'b0;
      chk(fault_irq == 1'b0, "R12", "irq cleared", {31'd0, fault_irq}, 32'd0);

      // R10 small page, both type codes
      expect_rd(l1a(32'h5671_2345), "R3");
      expect_rd(l2a(32'h0008_0401, 32'h5671_2345), "R7");
      xlat(1'b1, 32'h5671_2345, 32'h1357_9345, 1'b0, 2, 1, "R10");
      chk(fault_irq == 1'b0, "R12", "no irq on good walk", {31'd0, fault_irq}, 32'd0);
      expect_rd(l1a(32'h5673_4FFF), "R3");
      expect_rd(l2a(32'h0008_0401, 32'h5673_4FFF), "R7");
      xlat(1'b1, 32'h5673_4FFF, 32'hCAFE_BFFF, 1'b0, 2, 0, "R10");

      // R8 second-level fault while clear is held: set wins, then clear acts
      irq_clear = 1'b1;
      expect_rd(l1a(32'h5675_6000), "R3");
      expect_rd(l2a(32'h0008_0401, 32'h5675_6000), "R7");
      xlat(1'b1, 32'h5675_6000, 32'h0, 1'b1, 2, 1, "R8");
      chk(fault_irq == 1'b0, "R12", "held clear acts after set", {31'd0, fault_irq}, 32'd0);
      irq_clear = 1'b0;

      chk(exp_addr.size() == 0, "R3", "all expected reads seen", exp_addr.size(), 32'd0);
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule